// File: doc/BRIEF.md
# Exception Entry and Status Controller

This block owns the processor's current status word: four condition flags, two interrupt-disable bits and a five-bit mode field. It watches a set of exception sources (a synchronous reset request, undefined instruction, software call, instruction-fetch abort, data abort, and two interrupt request lines of differing urgency). When any source is active it chooses the most urgent one and acts on the next clock edge. It copies the current status into the saved-status slot of the target mode, switches the mode, raises the disable bits, and emits a one-cycle vector address together with a link-write strobe.

While no exception is pending, an ALU-side bus may overwrite the four flags. A return command restores the whole status word from the saved slot of the current mode. That copy covers the flags, the disable bits and the mode, so control drops back to the interrupted context. The saved slot of the current mode is visible on an output, so software-visible state can be observed at the boundary.

Top module: `exc_status_ctl`

## Requirements
- R1: After `rst_n` is deasserted, `status` reads 0xD3. That value means flags 0, I (bit 7) = 1, F (bit 6) = 1, and mode 5'b10011, which is supervisor. `spsr_out` reads 0x10 and `vec_valid` is 0.
- R2: In `status` and `spsr_out`, bits 27..8 and bit 5 always read 0. Bits 31..28 are N, Z, C, V.
- R3: The exception-to-mode mapping is fixed. Supervisor (5'b10011) is entered on request reset at vector offset 0x00 and on software call at offset 0x08. Undefined mode (5'b11011) is entered at 0x04. Abort mode (5'b10111) is entered on fetch abort at 0x0C and on data abort at 0x10. Interrupt mode (5'b10010) is entered at 0x18 and fast-interrupt mode (5'b10001) at 0x1C. Each offset is added to `VEC_BASE`.
- R4: When several sources are active together, the priority from highest to lowest is: request reset, data abort, fast interrupt, interrupt, fetch abort, undefined, software call.
- R5: `irq_req` is ignored while I is 1 and `fiq_req` is ignored while F is 1. The other sources cannot be masked.
- R6: On entry, the status word from before the edge is written into the saved slot of the target mode. After entry, `spsr_out` shows that value.
- R7: Every entry sets I. Request reset and fast-interrupt entry also set F. All other entries leave F unchanged, and every entry leaves the flags unchanged.
- R8: `ret_cmd` copies the current mode's saved slot into `status`, including the mode. `ret_cmd` has no effect in user mode (5'b10000), where `spsr_out` reads 0.
- R9: `flag_we` loads `flag_in` into bits 31..28. The flag write is dropped in a cycle that also takes an exception or performs a return.
- R10: `vec_valid` pulses for one cycle, one cycle after the source was sampled. `link_we` pulses with it on every entry except request reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Synchronous reset exception request |
| undef_evt | input | 1 | Undefined instruction event |
| swi_evt | input | 1 | Software call event |
| pabt_evt | input | 1 | Instruction-fetch abort event |
| dabt_evt | input | 1 | Data abort event |
| irq_req | input | 1 | Interrupt request level |
| fiq_req | input | 1 | Fast interrupt request level |
| flag_we | input | 1 | Flag update strobe from the ALU |
| flag_in | input | 4 | New N, Z, C, V values |
| ret_cmd | input | 1 | Return from handler |
| status | output | 32 | Current status word |
| spsr_out | output | 32 | Saved slot of the current mode (0 in user mode) |
| vec_valid | output | 1 | Vector address valid strobe |
| vec_addr | output | AW | Exception vector address |
| link_we | output | 1 | Link register write strobe |

## Verification
The bench raises several sources at once to check the priority order. A wrong order would send a data abort to the fast-interrupt handler, or a fetch abort past a pending interrupt. It raises interrupt requests while the matching disable bit is set; a design that ignored the masks would re-enter the handler and overwrite the saved status. It nests a software call inside the undefined handler and then returns twice, which exposes any design that keeps one shared saved slot or restores the wrong slot. It also combines a flag write with an entry or a return in the same cycle, and issues a return in user mode. A design that got these wrong would corrupt the saved flags or leave user mode.

// File: rtl/exc_status_ctl.sv
module exc_status_ctl #(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_req,
  input  logic          undef_evt,
  input  logic          swi_evt,
  input  logic          pabt_evt,
  input  logic          dabt_evt,
  input  logic          irq_req,
  input  logic          fiq_req,
  input  logic          flag_we,
  input  logic [3:0]    flag_in,
  input  logic          ret_cmd,
  output logic [31:0]   status,
  output logic [31:0]   spsr_out,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  output logic          link_we
);

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam int NBANK = 5;
  localparam logic [31:0] SAVED_INIT = {27'b0, M_USR};

  logic [3:0]  nzcv;
  logic        ib, fb;
  logic [4:0]  mode;
  logic [31:0] saved [NBANK];

  logic       take, set_f, lnk;
  logic [4:0] tgt;
  logic [7:0] off;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return 3'd0;
      M_IRQ:   return 3'd1;
      M_SVC:   return 3'd2;
      M_ABT:   return 3'd3;
      M_UND:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic banked(input logic [4:0] m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  assign status   = {nzcv, 20'b0, ib, fb, 1'b0, mode};
  assign spsr_out = banked(mode) ? saved[bank_of(mode)] : 32'b0;

  always_comb begin
    take  = 1'b1;
    tgt   = M_SVC;
    off   = 8'h00;
    set_f = 1'b0;
    lnk   = 1'b1;
    if (rst_req) begin
      set_f = 1'b1;
      lnk   = 1'b0;
    end else if (dabt_evt) begin
      tgt = M_ABT;
      off = 8'h10;
    end else if (fiq_req && !fb) begin
      tgt   = M_FIQ;
      off   = 8'h1C;
      set_f = 1'b1;
    end else if (irq_req && !ib) begin
      tgt = M_IRQ;
      off = 8'h18;
    end else if (pabt_evt) begin
      tgt = M_ABT;
      off = 8'h0C;
    end else if (undef_evt) begin
      tgt = M_UND;
      off = 8'h04;
    end else if (swi_evt) begin
      off = 8'h08;
    end else begin
      take = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzcv      <= 4'b0;
      ib        <= 1'b1;
      fb        <= 1'b1;
      mode      <= M_SVC;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      link_we   <= 1'b0;
      for (int k = 0; k < NBANK; k++) saved[k] <= SAVED_INIT;
    end else begin
      vec_valid <= 1'b0;
      link_we   <= 1'b0;
      if (take) begin
        saved[bank_of(tgt)] <= status;
        mode      <= tgt;
        ib        <= 1'b1;
        if (set_f) fb <= 1'b1;
        vec_valid <= 1'b1;
        vec_addr  <= VEC_BASE + AW'(off);
        link_we   <= lnk;
      end else if (ret_cmd && banked(mode)) begin
        nzcv <= saved[bank_of(mode)][31:28];
        ib   <= saved[bank_of(mode)][7];
        fb   <= saved[bank_of(mode)][6];
        mode <= saved[bank_of(mode)][4:0];
      end else if (flag_we) begin
        nzcv <= flag_in;
      end
    end
  end

endmodule

module exc_status_ctl_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic          undef_evt,
  input logic          swi_evt,
  input logic          pabt_evt,
  input logic          dabt_evt,
  input logic          irq_req,
  input logic          fiq_req,
  input logic          ret_cmd,
  input logic [31:0]   status,
  input logic [31:0]   spsr_out,
  input logic          vec_valid,
  input logic [AW-1:0] vec_addr,
  input logic          link_we
);

  AST_IRQ_VEC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_addr == VEC_BASE + AW'(8'h18) |-> status[4:0] == 5'b10010); // R3
  AST_SAVE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> spsr_out == $past(status)); // R6
  AST_ENTRY_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> status[7]); // R7
  AST_LINK_WITH_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> vec_valid); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_req && status[7] && !fiq_req && !dabt_evt && !rst_req &&
          !pabt_evt && !undef_evt && !swi_evt) |-> !vec_valid); // R5
  AST_USER_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ret_cmd && status[4:0] == 5'b10000) && !vec_valid
      |-> status[4:0] == 5'b10000); // R8

endmodule

bind exc_status_ctl exc_status_ctl_chk #(.AW(AW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .undef_evt(undef_evt),
  .swi_evt(swi_evt), .pabt_evt(pabt_evt), .dabt_evt(dabt_evt),
  .irq_req(irq_req), .fiq_req(fiq_req), .ret_cmd(ret_cmd),
  .status(status), .spsr_out(spsr_out), .vec_valid(vec_valid),
  .vec_addr(vec_addr), .link_we(link_we)
);

// File: tb/exc_status_ctl_bench.sv
module exc_status_ctl_bench;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 0, undef_evt = 0, swi_evt = 0, pabt_evt = 0, dabt_evt = 0;
  logic irq_req = 0, fiq_req = 0, flag_we = 0, ret_cmd = 0;
  logic [3:0] flag_in = 4'h0;
  logic [31:0] status, spsr_out;
  logic vec_valid, link_we;
  logic [AW-1:0] vec_addr;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  exc_status_ctl u_exc_status_ctl (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .undef_evt(undef_evt),
    .swi_evt(swi_evt), .pabt_evt(pabt_evt), .dabt_evt(dabt_evt),
    .irq_req(irq_req), .fiq_req(fiq_req), .flag_we(flag_we),
    .flag_in(flag_in), .ret_cmd(ret_cmd), .status(status),
    .spsr_out(spsr_out), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .link_we(link_we)
  );

  typedef struct {
    string       tag;
    logic [31:0] st;
    logic [31:0] sp;
    logic        vv;
    logic [7:0]  off;
    logic        lw;
  } exp_t;

  exp_t q[$];

  function automatic logic [31:0] mk(input logic [3:0] f, input logic i,
                                     input logic fi, input logic [4:0] m);
    return {f, 20'b0, i, fi, 1'b0, m};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ev = {rst_req, dabt, fiq, irq, pabt, undef, swi}
  task automatic drv(input string tag, input logic [6:0] ev, input logic fw,
                     input logic [3:0] fl, input logic rt, input logic [31:0] st,
                     input logic [31:0] sp, input logic vv, input logic [7:0] off,
                     input logic lw);
    exp_t e;
    @(negedge clk);
    {rst_req, dabt_evt, fiq_req, irq_req, pabt_evt, undef_evt, swi_evt} = ev;
    flag_we = fw;
    flag_in = fl;
    ret_cmd = rt;
    e.tag = tag; e.st = st; e.sp = sp; e.vv = vv; e.off = off; e.lw = lw;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #3;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " status"}, 64'(status), 64'(e.st));
      chk({e.tag, " saved"}, 64'(spsr_out), 64'(e.sp));
      chk({e.tag, " strobes"}, {61'b0, vec_valid, link_we, 1'b0}, {61'b0, e.vv, e.lw, 1'b0});
      if (e.vv) chk({e.tag, " vector"}, 64'(vec_addr), 64'(e.off));
      chk({e.tag, " R2 reserved bits"}, {32'b0, status[27:8], 11'b0, status[5]}, 64'b0);
    end
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset status", 64'(status), 64'h0D3);
    chk("R1 reset saved", 64'(spsr_out), 64'h10);
    chk("R1 reset no vector", 64'(vec_valid), 64'h0);

    drv("R8 return to user", 7'b0, 0, 4'h0, 1, 32'h10, 32'h0, 0, 8'h00, 0);
    drv("R9 flag write", 7'b0, 1, 4'hA, 0, 32'hA0000010, 32'h0, 0, 8'h00, 0);
    drv("R8 user return ignored", 7'b0, 0, 4'h0, 1, 32'hA0000010, 32'h0, 0, 8'h00, 0);
    drv("R3 R6 irq entry", 7'b0001000, 0, 4'h0, 0, mk(4'hA,1,0,5'h12), 32'hA0000010, 1, 8'h18, 1);
    drv("R5 irq masked", 7'b0001000, 0, 4'h0, 0, mk(4'hA,1,0,5'h12), 32'hA0000010, 0, 8'h00, 0);
    drv("R4 R7 fiq over irq", 7'b0011000, 0, 4'h0, 0, mk(4'hA,1,1,5'h11), mk(4'hA,1,0,5'h12), 1, 8'h1C, 1);
    drv("R9 R8 return drops flags", 7'b0, 1, 4'h5, 1, mk(4'hA,1,0,5'h12), 32'hA0000010, 0, 8'h00, 0);
    drv("R8 return irq", 7'b0, 0, 4'h0, 1, 32'hA0000010, 32'h0, 0, 8'h00, 0);
    drv("R4 dabt wins", 7'b0111111, 0, 4'h0, 0, mk(4'hA,1,0,5'h17), 32'hA0000010, 1, 8'h10, 1);
    drv("R8 return abt", 7'b0, 0, 4'h0, 1, 32'hA0000010, 32'h0, 0, 8'h00, 0);
    drv("R4 fiq over pabt", 7'b0011100, 0, 4'h0, 0, mk(4'hA,1,1,5'h11), 32'hA0000010, 1, 8'h1C, 1);
    drv("R8 return fiq", 7'b0, 0, 4'h0, 1, 32'hA0000010, 32'h0, 0, 8'h00, 0);
    drv("R4 irq over pabt", 7'b0001110, 0, 4'h0, 0, mk(4'hA,1,0,5'h12), 32'hA0000010, 1, 8'h18, 1);
    drv("R8 return irq 2", 7'b0, 0, 4'h0, 1, 32'hA0000010, 32'h0, 0, 8'h00, 0);
    drv("R4 R3 pabt over undef", 7'b0000111, 0, 4'h0, 0, mk(4'hA,1,0,5'h17), 32'hA0000010, 1, 8'h0C, 1);
    drv("R8 return abt 2", 7'b0, 0, 4'h0, 1, 32'hA0000010, 32'h0, 0, 8'h00, 0);
    drv("R4 R3 undef over swi", 7'b0000011, 0, 4'h0, 0, mk(4'hA,1,0,5'h1B), 32'hA0000010, 1, 8'h04, 1);
    drv("R9 flag write in und", 7'b0, 1, 4'h3, 0, mk(4'h3,1,0,5'h1B), 32'hA0000010, 0, 8'h00, 0);
    drv("R3 R6 nested swi", 7'b0000001, 0, 4'h0, 0, mk(4'h3,1,0,5'h13), mk(4'h3,1,0,5'h1B), 1, 8'h08, 1);
    drv("R8 return to und", 7'b0, 0, 4'h0, 1, mk(4'h3,1,0,5'h1B), 32'hA0000010, 0, 8'h00, 0);
    drv("R8 return to user", 7'b0, 0, 4'h0, 1, 32'hA0000010, 32'h0, 0, 8'h00, 0);
    drv("R9 entry drops flags", 7'b0001000, 1, 4'h0, 0, mk(4'hA,1,0,5'h12), 32'hA0000010, 1, 8'h18, 1);
    drv("R10 R4 request reset", 7'b1100000, 0, 4'h0, 0, mk(4'hA,1,1,5'h13), mk(4'hA,1,0,5'h12), 1, 8'h00, 0);
    drv("R5 fiq masked", 7'b0010000, 0, 4'h0, 0, mk(4'hA,1,1,5'h13), mk(4'hA,1,0,5'h12), 0, 8'h00, 0);
    drv("R8 return svc to irq", 7'b0, 0, 4'h0, 1, mk(4'hA,1,0,5'h12), 32'hA0000010, 0, 8'h00, 0);
    drv("R7 fiq inside irq", 7'b0010000, 0, 4'h0, 0, mk(4'hA,1,1,5'h11), mk(4'hA,1,0,5'h12), 1, 8'h1C, 1);
    drv("R10 strobe single cycle", 7'b0, 0, 4'h0, 0, mk(4'hA,1,1,5'h11), mk(4'hA,1,0,5'h12), 0, 8'h00, 0);

    @(negedge clk);
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule